// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port with Two-Entry Receive Queue

This block is a full-duplex asynchronous serial port. Software sets the character format (seven or eight data bits, parity off or on with an odd or even sense, one or two stop bits) and moves bytes through a small byte-wide register interface. The transmit path has a one-byte holding register that feeds a frame shift register. The receive path places finished characters in a two-entry queue that is read oldest first.

Bit timing comes from an external baud generator. It delivers a one-clock pulse on `tick16` at sixteen times the bit rate. The receiver uses these pulses to find the falling start edge, confirms the start bit at mid-bit and samples every later bit at its centre. Four interrupt causes, each with its own enable, are ORed onto a single `irq` output. A master enable bit gates both directions.

Top module: `serial_port`

## Requirements
- R1: After reset, status (address 0) reads 0x01, format (address 3) and control (address 4) read 0x00, `txd` is 1 and `irq` is 0.
- R2: A frame is a low start bit, then the data bits LSB first, then the optional parity bit, then the stop bits, each 16 ticks long. Format bit 0 = 1 selects 8 data bits. Format bit 0 = 0 selects 7 data bits: data bit 7 is neither sent nor received, and received 7-bit data reads with bit 7 = 0.
- R3: Format bit 1 = 1 adds a parity bit after the data bits. Format bit 2 selects odd parity (1) or even parity (0), computed over the data bits that are in use.
- R4: Format bit 3 = 1 sends two high stop bits; 0 sends one.
- R5: A write to address 1 fills the transmit holding register when it is empty. Status bit 0 reads 1 when the holding register is empty. Status bit 2 reads 1 while a frame is being shifted out.
- R6: Status bit 7 (end of transmission) sets when a frame finishes and no byte is waiting. It stays set until software writes 1 to that bit.
- R7: Received characters enter a two-entry queue. Reading address 2 returns the oldest entry and removes it. Status bit 1 reads 1 when at least one entry is held. Status bit 3 reads 1 when two entries are held.
- R8: When a character completes while two entries are held, status bit 4 (overrun) sets, the new character is dropped and the held entries are kept.
- R9: Status bit 5 sets when the received parity bit is wrong. Status bit 6 sets when the first stop bit samples low. The character is still queued. Writing 1 to status bits 4 to 6 clears them.
- R10: `irq` = (ctl7 and status bit 7) or (ctl6 and any of status bits 4 to 6) or (ctl5 and queue full) or (ctl4 and status bit 0). Queue full means two entries held when ctl1 = 1, and at least one entry when ctl1 = 0.
- R11: While control bit 0 is 0, no frame starts on `txd` and incoming frames are not queued. A byte already in the holding register is sent once the bit is set.
- R12: Reserved bits read 0: format bits 7 to 4, control bits 3 to 2, and every address above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Oversampling pulse, 16 per bit |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe (pops the queue at address 2) |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, idle high |
| irq | output | 1 | Combined interrupt |

## Verification
The transmitter is tried with three formats: 8N1, 7 bits with even parity and two stop bits, and 8 bits with odd parity. These tell apart errors in frame length, in parity sense and in stop-bit count. On the receive side, two back-to-back characters show that the queue is ordered. A third character shows that the overrun drops the newcomer and keeps the held entries. Frames with a deliberately wrong parity bit and with a low stop bit tell the two error flags apart. The interrupt checks compare the one-entry and two-entry full thresholds on the same traffic.

// File: rtl/serial_port_pkg.sv
// Shared types and frame helpers for the serial port.
// Assumes frames of at most 12 bits: start + 8 data + parity + 2 stop.
package serial_port_pkg;

    typedef struct packed {
        logic stop2;
        logic odd;
        logic par_en;
        logic len8;
    } fmt_t;

    localparam logic [2:0] ADR_STAT = 3'd0;
    localparam logic [2:0] ADR_TXD  = 3'd1;
    localparam logic [2:0] ADR_RXD  = 3'd2;
    localparam logic [2:0] ADR_FMT  = 3'd3;
    localparam logic [2:0] ADR_CTL  = 3'd4;
    localparam int FRAME_W = 12;

    // Parity bit over the active data bits.
    function automatic logic parity_of(input logic [7:0] d, input fmt_t f);
        logic [7:0] m;
        m = f.len8 ? d : {1'b0, d[6:0]};
        return (^m) ^ f.odd;
    endfunction

    // Number of bit slots in one frame.
    function automatic logic [3:0] frame_len(input fmt_t f);
        return 4'd1 + (f.len8 ? 4'd8 : 4'd7) + {3'b000, f.par_en} + (f.stop2 ? 4'd2 : 4'd1);
    endfunction

    // Full frame, LSB sent first, unused upper slots high.
    function automatic logic [FRAME_W-1:0] build_frame(input logic [7:0] d, input fmt_t f);
        logic [FRAME_W-1:0] fr;
        fr = '1;
        fr[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < 7 || f.len8) fr[i+1] = d[i];
        end
        if (f.par_en) begin
            if (f.len8) fr[9] = parity_of(d, f);
            else        fr[8] = parity_of(d, f);
        end
        return fr;
    endfunction

endpackage

// File: rtl/serial_tx.sv
// Frame transmitter: loads a whole frame into a shift register and moves
// one slot every TICKS oversampling pulses. Assumes start only when idle.
module serial_tx
    import serial_port_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic [7:0] data,
    input  fmt_t       fmt,
    output logic       txd,
    output logic       busy,
    output logic       done
);
    localparam int TW = $clog2(TICKS);

    logic [FRAME_W-1:0] sh_q;
    logic [3:0]         left_q;
    logic [TW-1:0]      tcnt_q;
    logic               slot_end;

    assign slot_end = busy && tick && (tcnt_q == TW'(TICKS - 1));
    assign done     = slot_end && (left_q == 4'd0);
    assign txd      = busy ? sh_q[0] : 1'b1;

    // Load a frame, then shift it out slot by slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '1;
            left_q <= '0;
            tcnt_q <= '0;
            busy   <= 1'b0;
        end else if (start && !busy) begin
            sh_q   <= build_frame(data, fmt);
            left_q <= frame_len(fmt) - 4'd1;
            tcnt_q <= '0;
            busy   <= 1'b1;
        end else if (busy && tick) begin
            if (slot_end) begin
                tcnt_q <= '0;
                if (left_q == 4'd0) begin
                    busy <= 1'b0;
                end else begin
                    sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
                    left_q <= left_q - 4'd1;
                end
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
    end

    // Each frame opens with a low start bit.
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

endmodule

// File: rtl/serial_rx.sv
// Frame receiver: after a falling edge it confirms the start bit at mid-bit,
// then samples each later bit at its centre. Needs the line high again
// before it accepts a new start edge (guards against a low stop bit).
module serial_rx
    import serial_port_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       rxd,
    input  fmt_t       fmt,
    output logic       done,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr
);
    localparam int TW = $clog2(TICKS);
    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_t;

    rx_state_t     st_q;
    logic [1:0]    sync_q;
    logic          rx;
    logic          armed_q;
    logic [TW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic          mid;

    assign rx   = sync_q[1];
    assign mid  = tick && (cnt_q == TW'(TICKS - 1));
    assign data = fmt.len8 ? sh_q : {1'b0, sh_q[7:1]};
    assign done = (st_q == S_STOP) && mid;
    assign ferr = !rx;

    // Two-flop synchronizer on the serial input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // Receive state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            armed_q <= 1'b0;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            perr    <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (rx) armed_q <= 1'b1;
                    if (en && armed_q && tick && !rx) begin
                        st_q    <= S_START;
                        armed_q <= 1'b0;
                        cnt_q   <= '0;
                        perr    <= 1'b0;
                    end
                end
                S_START: if (tick) begin
                    if (cnt_q == TW'(TICKS / 2 - 1)) begin
                        cnt_q <= '0;
                        bit_q <= '0;
                        st_q  <= rx ? S_IDLE : S_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_DATA: if (tick) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (mid) begin
                        sh_q  <= {rx, sh_q[7:1]};
                        bit_q <= bit_q + 3'd1;
                        if (bit_q == (fmt.len8 ? 3'd7 : 3'd6))
                            st_q <= fmt.par_en ? S_PAR : S_STOP;
                    end
                end
                S_PAR: if (tick) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (mid) begin
                        perr <= rx ^ parity_of(data, fmt);
                        st_q <= S_STOP;
                    end
                end
                default: if (tick) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (mid) st_q <= S_IDLE;
                end
            endcase
        end
    end

    // A confirmed start bit must have been low at mid-bit.
    assert_start_confirm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_START && $past(st_q) == S_START && tick && cnt_q == TW'(TICKS / 2 - 1) && !rx)
        |=> st_q == S_DATA);

endmodule

// File: rtl/serial_rxq.sv
// Two-entry receive queue, oldest entry at the head. Assumes at most one
// push and one pop per cycle; a push into a full queue without a pop is dropped.
module serial_rxq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic [1:0]   count,
    output logic         drop
);
    logic [W-1:0] e0_q, e1_q;
    logic         pop_ok, push_ok;

    assign pop_ok  = pop && (count != 2'd0);
    assign push_ok = push && (count != 2'd2 || pop_ok);
    assign drop    = push && !push_ok;
    assign head    = (count != 2'd0) ? e0_q : '0;

    // Queue update for push, pop or both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e0_q  <= '0;
            e1_q  <= '0;
            count <= 2'd0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10: begin
                    if (count == 2'd0) e0_q <= din;
                    else               e1_q <= din;
                    count <= count + 2'd1;
                end
                2'b01: begin
                    e0_q  <= e1_q;
                    count <= count - 2'd1;
                end
                2'b11: begin
                    if (count == 2'd1) begin
                        e0_q <= din;
                    end else begin
                        e0_q <= e1_q;
                        e1_q <= din;
                    end
                end
                default: ;
            endcase
        end
    end

    // A push into a full queue keeps the held entries.
    assert_full_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && count == 2'd2) |=> (count == 2'd2 && $stable(e0_q) && $stable(e1_q)));

    // Popping the only entry empties the queue.
    assert_pop_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && count == 2'd1) |=> count == 2'd0);

endmodule

// File: rtl/serial_port.sv
// Register front end of the serial port: format and control registers,
// transmit holding register, sticky status flags and interrupt combine.
// Assumes tick16 comes from an external baud generator, one clock wide.
module serial_port
    import serial_port_pkg::*;
#(
    parameter int TICKS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_rd,
    output logic [7:0] reg_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq
);
    fmt_t       fmt_q;
    logic       en_q, two_q, ie_txe_q, ie_rxf_q, ie_err_q, ie_eot_q;
    logic       eot_q, fe_q, pe_q, oe_q;
    logic [7:0] hold_q;
    logic       hold_v_q;
    logic       tx_busy, tx_done, tx_start;
    logic       rx_done, rx_perr, rx_ferr, q_drop, q_pop;
    logic [7:0] rx_data, q_head;
    logic [1:0] q_count;
    logic       wr_stat, q_full;
    logic [7:0] status;

    assign wr_stat  = reg_wr && reg_addr == ADR_STAT;
    assign tx_start = hold_v_q && en_q && !tx_busy;
    assign q_pop    = reg_rd && reg_addr == ADR_RXD;
    assign q_full   = two_q ? (q_count == 2'd2) : (q_count != 2'd0);
    assign status   = {eot_q, fe_q, pe_q, oe_q, q_count == 2'd2, tx_busy, q_count != 2'd0, !hold_v_q};

    serial_tx #(.TICKS(TICKS)) tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .start(tx_start), .data(hold_q),
        .fmt(fmt_q), .txd(txd), .busy(tx_busy), .done(tx_done));

    serial_rx #(.TICKS(TICKS)) rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .en(en_q), .rxd(rxd), .fmt(fmt_q),
        .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr));

    serial_rxq #(.W(8)) q_i (
        .clk(clk), .rst_n(rst_n), .push(rx_done), .din(rx_data), .pop(q_pop),
        .head(q_head), .count(q_count), .drop(q_drop));

    // Format and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q <= '0;
            {ie_eot_q, ie_err_q, ie_rxf_q, ie_txe_q, two_q, en_q} <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADR_FMT) fmt_q <= fmt_t'(reg_wdata[3:0]);
            if (reg_addr == ADR_CTL)
                {ie_eot_q, ie_err_q, ie_rxf_q, ie_txe_q, two_q, en_q} <=
                    {reg_wdata[7:4], reg_wdata[1:0]};
        end
    end

    // Transmit holding register: filled by software, drained by the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            hold_v_q <= 1'b0;
        end else if (tx_start) begin
            hold_v_q <= 1'b0;
        end else if (reg_wr && reg_addr == ADR_TXD && !hold_v_q) begin
            hold_q   <= reg_wdata;
            hold_v_q <= 1'b1;
        end
    end

    // Sticky status flags: hardware sets win over write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {eot_q, fe_q, pe_q, oe_q} <= '0;
        end else begin
            eot_q <= (tx_done && !hold_v_q) || (eot_q && !(wr_stat && reg_wdata[7]));
            fe_q  <= (rx_done && rx_ferr)   || (fe_q  && !(wr_stat && reg_wdata[6]));
            pe_q  <= (rx_done && rx_perr)   || (pe_q  && !(wr_stat && reg_wdata[5]));
            oe_q  <= q_drop                 || (oe_q  && !(wr_stat && reg_wdata[4]));
        end
    end

    // Read multiplexer; unused bits and addresses read 0.
    always_comb begin
        case (reg_addr)
            ADR_STAT: reg_rdata = status;
            ADR_TXD:  reg_rdata = hold_q;
            ADR_RXD:  reg_rdata = q_head;
            ADR_FMT:  reg_rdata = {4'h0, fmt_q};
            ADR_CTL:  reg_rdata = {ie_eot_q, ie_err_q, ie_rxf_q, ie_txe_q, 2'b00, two_q, en_q};
            default:  reg_rdata = 8'h00;
        endcase
    end

    // Interrupt combine.
    assign irq = (ie_eot_q && eot_q) || (ie_err_q && (fe_q || pe_q || oe_q)) ||
                 (ie_rxf_q && q_full) || (ie_txe_q && !hold_v_q);

    assert_eot_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[7] && !tx_done) |=> !eot_q);

    assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !$rose(tx_busy));

    assert_ferr_from_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe_q) |-> $past(rx_done));

    assert_hold_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADR_TXD && !hold_v_q) |=> !status[0]);

endmodule

// File: tb/serial_port_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module serial_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       rxd = 1'b1;
    logic       txd, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    localparam int BITCLK = 64;   // 16 ticks of 4 clocks

    serial_port dut_i (.clk(clk), .rst_n(rst_n), .tick16(tick16), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .rxd(rxd), .txd(txd), .irq(irq));

    always #4 clk = ~clk;

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // Expected frame from the format: start, data LSB first, parity, stops.
    function automatic void model(input logic [7:0] d, input logic [3:0] f, input bit bad_par,
                                  input bit stop_low, output logic [11:0] bits, output int n);
        int nd;
        logic p;
        nd = f[0] ? 8 : 7;
        p = ((f[0] ? ^d : ^d[6:0]) ^ f[2]) ^ bad_par;
        bits = '1; bits[0] = 1'b0; n = 1;
        for (int i = 0; i < nd; i++) begin bits[n] = d[i]; n++; end
        if (f[1]) begin bits[n] = p; n++; end
        bits[n] = !stop_low; n++;
        if (f[3]) n++;
    endfunction

    task automatic send(input logic [7:0] d, input logic [3:0] f, input bit bad_par, input bit stop_low);
        logic [11:0] bits;
        int n;
        model(d, f, bad_par, stop_low, bits, n);
        for (int i = 0; i < n; i++) begin
            rxd = bits[i];
            repeat (BITCLK) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (2 * BITCLK) @(negedge clk);
    endtask

    task automatic capture(input int n, output logic [11:0] got);
        int guard = 0;
        got = '1;
        while (txd !== 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
        repeat (BITCLK / 2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            got[i] = txd;
            repeat (BITCLK) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(3'd0, v); chk("R1 status", {4'h0, v}, 12'h001);
        rd(3'd3, v); chk("R1 format", {4'h0, v}, 12'h000);
        rd(3'd4, v); chk("R1 control", {4'h0, v}, 12'h000);
        chk("R1 txd idle", {11'h0, txd}, 12'h001);
        chk("R1 irq", {11'h0, irq}, 12'h000);
    endtask

    task automatic t_tx(input logic [3:0] f, input logic [7:0] d, input string tag);
        logic [11:0] exp, got;
        int n;
        logic [7:0] v;
        model(d, f, 1'b0, 1'b0, exp, n);
        wr(3'd3, {4'h0, f});
        wr(3'd4, 8'h01);
        wr(3'd0, 8'hF0);
        wr(3'd1, d);
        repeat (4) @(negedge clk);
        rd(3'd0, v); chk({tag, " R5 busy and empty"}, {4'h0, v & 8'h05}, 12'h005);
        capture(n, got);
        chk({tag, " R2 R3 R4 frame"}, got, exp);
        repeat (BITCLK) @(negedge clk);
        rd(3'd0, v); chk({tag, " R6 end of tx"}, {4'h0, v}, 12'h081);
    endtask

    task automatic t_eot_clear;
        logic [7:0] v;
        wr(3'd0, 8'h80);
        rd(3'd0, v); chk("R6 write one clears", {4'h0, v}, 12'h001);
    endtask

    task automatic t_rx_pair;
        logic [7:0] v;
        wr(3'd3, 8'h01); wr(3'd4, 8'h01);
        send(8'h3C, 4'h1, 0, 0);
        send(8'hC3, 4'h1, 0, 0);
        rd(3'd0, v); chk("R7 two held", {4'h0, v & 8'h0A}, 12'h00A);
        rd(3'd2, v); chk("R7 oldest", {4'h0, v}, 12'h03C);
        rd(3'd2, v); chk("R7 second", {4'h0, v}, 12'h0C3);
        rd(3'd0, v); chk("R7 empty", {4'h0, v & 8'h0A}, 12'h000);
    endtask

    task automatic t_rx7;
        logic [7:0] v;
        wr(3'd3, 8'h00);
        send(8'h7F, 4'h0, 0, 0);
        rd(3'd2, v); chk("R2 seven bit rx", {4'h0, v}, 12'h07F);
    endtask

    task automatic t_overrun;
        logic [7:0] v;
        wr(3'd3, 8'h01);
        send(8'h11, 4'h1, 0, 0);
        send(8'h22, 4'h1, 0, 0);
        send(8'h33, 4'h1, 0, 0);
        rd(3'd0, v); chk("R8 overrun flag", {4'h0, v & 8'h10}, 12'h010);
        rd(3'd2, v); chk("R8 kept first", {4'h0, v}, 12'h011);
        rd(3'd2, v); chk("R8 kept second", {4'h0, v}, 12'h022);
        rd(3'd0, v); chk("R8 new dropped", {4'h0, v & 8'h02}, 12'h000);
        wr(3'd0, 8'h10);
        rd(3'd0, v); chk("R9 overrun cleared", {4'h0, v & 8'h10}, 12'h000);
    endtask

    task automatic t_errors;
        logic [7:0] v;
        wr(3'd3, 8'h03);
        send(8'h55, 4'h3, 1, 0);
        rd(3'd0, v); chk("R9 parity flag", {4'h0, v & 8'h70}, 12'h020);
        rd(3'd2, v); chk("R9 parity data kept", {4'h0, v}, 12'h055);
        wr(3'd0, 8'h20);
        wr(3'd3, 8'h01);
        send(8'h81, 4'h1, 0, 1);
        rd(3'd0, v); chk("R9 framing flag", {4'h0, v & 8'h70}, 12'h040);
        rd(3'd2, v); chk("R9 framing data kept", {4'h0, v}, 12'h081);
        wr(3'd0, 8'h40);
        rd(3'd0, v); chk("R9 flags cleared", {4'h0, v & 8'h70}, 12'h000);
    endtask

    task automatic t_irq;
        logic [7:0] v;
        wr(3'd4, 8'h23);
        send(8'hA1, 4'h1, 0, 0);
        chk("R10 two-threshold one byte", {11'h0, irq}, 12'h000);
        send(8'hA2, 4'h1, 0, 0);
        chk("R10 two-threshold two bytes", {11'h0, irq}, 12'h001);
        rd(3'd2, v);
        chk("R10 after pop", {11'h0, irq}, 12'h000);
        wr(3'd4, 8'h21);
        chk("R10 one-threshold", {11'h0, irq}, 12'h001);
        rd(3'd2, v);
        chk("R10 drained", {11'h0, irq}, 12'h000);
        wr(3'd4, 8'h41);
        chk("R10 no error", {11'h0, irq}, 12'h000);
        wr(3'd4, 8'h11);
        chk("R10 tx empty", {11'h0, irq}, 12'h001);
        wr(3'd4, 8'h01);
    endtask

    task automatic t_disable;
        logic [7:0] v;
        logic [11:0] exp, got;
        int n;
        bit moved = 1'b0;
        wr(3'd4, 8'h00);
        send(8'h66, 4'h1, 0, 0);
        rd(3'd0, v); chk("R11 rx not queued", {4'h0, v & 8'h02}, 12'h000);
        wr(3'd1, 8'h4B);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) moved = 1'b1;
        end
        chk("R11 txd quiet", {11'h0, moved}, 12'h000);
        rd(3'd0, v); chk("R11 byte waiting", {4'h0, v & 8'h01}, 12'h000);
        model(8'h4B, 4'h1, 1'b0, 1'b0, exp, n);
        wr(3'd4, 8'h01);
        capture(n, got);
        chk("R11 sent after enable", got, exp);
        repeat (BITCLK) @(negedge clk);
        wr(3'd0, 8'hF0);
    endtask

    task automatic t_reserved;
        logic [7:0] v;
        wr(3'd3, 8'hFF);
        rd(3'd3, v); chk("R12 format reserved", {4'h0, v}, 12'h00F);
        wr(3'd4, 8'hCE);
        rd(3'd4, v); chk("R12 control reserved", {4'h0, v}, 12'h0C2);
        rd(3'd5, v); chk("R12 unused address", {4'h0, v}, 12'h000);
        wr(3'd4, 8'h00);
        wr(3'd3, 8'h01);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_tx(4'h1, 8'hA5, "8N1");
        t_eot_clear;
        t_tx(4'hA, 8'hDA, "7E2");
        t_tx(4'h7, 8'h03, "8O1");
        t_rx_pair;
        t_rx7;
        t_overrun;
        t_errors;
        t_irq;
        t_disable;
        t_reserved;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule